// File: doc/BRIEF.md
# Tagged Address Translation Cache with Protection Faults

This block is a fully associative cache of page mappings. Each entry holds a virtual page number, an address-space tag, a frame number and six flag bits. In the same cycle that a lookup is presented, the block compares the page number and the current address-space identifier against every entry. It returns the frame number on a hit. Otherwise it returns a fault class: a miss, a write to a read-only page, or an instruction fetch from a non-executable page.

The page walk is done outside the block. Its result comes in through a fill port. A fill is tagged with the identifier held in the block's address-space register, which is written on a context switch. A fill goes into an existing entry with the same page and tag if one exists. Failing that, it goes into the lowest-numbered invalid entry. When every entry is valid, a round-robin pointer picks the victim. Two more ports clear entries: one clears the entries that carry a given page number, and one clears every entry.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports fault code 1 (miss) with hit low. The address-space register resets to 0.
- R2: A lookup whose page and current address-space identifier match a valid entry, and whose access is permitted, drives hit high, fault code 0 and the entry's frame number in the same cycle.
- R3: An entry matches only when its tag equals the current address-space identifier. With a different identifier the same page misses.
- R4: Fault code 1 means no matching entry. The access type on `lk_acc` is coded 0 for read, 1 for write, 2 for fetch, and 3 is treated as a read. `lk_is_write` is 1 only for code 1.
- R5: A write that matches an entry whose writable flag (bit 1) is clear gives fault code 2 with hit low.
- R6: A fetch that matches an entry whose execute flag (bit 5) is clear gives fault code 3 with hit low. Reads of that entry still hit.
- R7: A lookup that hits sets the entry's referenced flag (bit 4) at the next clock edge. A hitting write also sets the dirty flag (bit 3). A faulting lookup sets neither. The matched entry's flags appear on `lk_flags`.
- R8: A page invalidate clears every entry with that page number, whatever its tag, and leaves other pages valid.
- R9: Invalidate-all clears the valid flag (bit 0) of every entry.
- R10: A fill with no matching entry takes the lowest-indexed invalid entry. When the cache is full, it replaces the entry at a round-robin pointer, which starts at index 0 and advances by one only on such evictions.
- R11: A fill whose page and tag match a valid entry overwrites that entry, so at most one entry ever matches a lookup.
- R12: With `lk_valid` low, hit is low and the fault code is 0.
- R13: `asid_we` loads `asid_wdata` into the address-space register at the clock edge. A fill is tagged with the register value, and the valid flag is forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_we | input | 1 | Write enable for the address-space register |
| asid_wdata | input | 8 | New address-space identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_hit | output | 1 | Permitted hit |
| lk_pfn | output | 20 | Frame number of the matched entry |
| lk_fault | output | 2 | 0 none, 1 miss, 2 read-only, 3 no-execute |
| lk_is_write | output | 1 | Lookup was a write |
| lk_flags | output | 6 | Flags of the matched entry, 0 if none |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_flags | input | 6 | Flags to install (valid forced) |
| inv_en | input | 1 | Invalidate by page |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The single-match assertion assumes that entries change only through the fill port. It also assumes that a fill and a page invalidate never target the same entry in one cycle. The bench never drives a fill, an invalidate or an address-space write in the same cycle as another of them. The protection-fault assertions assume that `lk_flags` bit 0 is set exactly when an entry matched. The stimulus covers that case by reading flags only from lookups it expects to match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W       = 20;
    localparam int PFN_W       = 20;
    localparam int ASID_W      = 8;
    localparam int TLB_ENTRIES = 64;
    localparam int FLAG_W      = 6;

    localparam int FB_V = 0;
    localparam int FB_W = 1;
    localparam int FB_C = 2;
    localparam int FB_D = 3;
    localparam int FB_R = 4;
    localparam int FB_X = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_RO   = 2'd2,
        FLT_NX   = 2'd3
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic [FLAG_W-1:0] flags;
    } tlb_entry_t;

    function automatic fault_e classify(input logic req, input logic matched,
                                        input logic [FLAG_W-1:0] fl,
                                        input logic [1:0] acc);
        if (!req)                                  return FLT_NONE;
        if (!matched)                              return FLT_MISS;
        if (acc == ACC_WRITE && !fl[FB_W])         return FLT_RO;
        if (acc == ACC_FETCH && !fl[FB_X])         return FLT_NX;
        return FLT_NONE;
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = TLB_ENTRIES
) (
    input  tlb_entry_t              ent [N],
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [ASID_W-1:0]       key_asid,
    input  logic                    use_asid,
    output logic [N-1:0]            match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent[i].flags[FB_V]
                        && (ent[i].vpn == key_vpn)
                        && (!use_asid || ent[i].asid == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 64,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] idx,
    output logic          evict
);
    always_comb begin
        idx   = rr_ptr;
        evict = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                idx   = IW'(i);
                evict = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              asid_we,
    input  logic [7:0]        asid_wdata,
    input  logic              lk_valid,
    input  logic [19:0]       lk_vpn,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic [19:0]       lk_pfn,
    output logic [1:0]        lk_fault,
    output logic              lk_is_write,
    output logic [5:0]        lk_flags,
    input  logic              fill_en,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_pfn,
    input  logic [5:0]        fill_flags,
    input  logic              inv_en,
    input  logic [19:0]       inv_vpn,
    input  logic              inv_all
);
    tlb_entry_t          ent_q [ENTRIES];
    logic [ASID_W-1:0]   asid_q;
    logic [IW-1:0]       rr_q;

    logic [ENTRIES-1:0]  valid_vec, lk_match, fill_match, inv_match;
    logic [IW-1:0]       vict_idx, fmatch_idx, fill_idx;
    logic                vict_evict, any_lk, any_fill;
    fault_e              fault;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_valid
        assign valid_vec[i] = ent_q[i].flags[FB_V];
    end

    tlb_cam #(.N(ENTRIES)) u_cam_lk (
        .ent(ent_q), .key_vpn(lk_vpn), .key_asid(asid_q),
        .use_asid(1'b1), .match(lk_match));
    tlb_cam #(.N(ENTRIES)) u_cam_fill (
        .ent(ent_q), .key_vpn(fill_vpn), .key_asid(asid_q),
        .use_asid(1'b1), .match(fill_match));
    tlb_cam #(.N(ENTRIES)) u_cam_inv (
        .ent(ent_q), .key_vpn(inv_vpn), .key_asid(asid_q),
        .use_asid(1'b0), .match(inv_match));

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid_vec(valid_vec), .rr_ptr(rr_q),
        .idx(vict_idx), .evict(vict_evict));

    // Read mux: at most one entry matches, so an OR of gated fields suffices.
    always_comb begin
        lk_pfn   = '0;
        lk_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_pfn   = lk_pfn | ent_q[i].pfn;
                lk_flags = lk_flags | ent_q[i].flags;
            end
        end
    end

    always_comb begin
        fmatch_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) fmatch_idx = IW'(i);
        end
    end

    assign any_lk      = |lk_match;
    assign any_fill    = |fill_match;
    assign fill_idx    = any_fill ? fmatch_idx : vict_idx;
    assign fault       = classify(lk_valid, any_lk, lk_flags, lk_acc);
    assign lk_fault    = fault;
    assign lk_hit      = lk_valid && any_lk && (fault == FLT_NONE);
    assign lk_is_write = (lk_acc == ACC_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            asid_q <= '0;
            rr_q   <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            if (asid_we) asid_q <= asid_wdata;
            if (fill_en && !inv_all && !any_fill && vict_evict)
                rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all) begin
                    ent_q[i].flags[FB_V] <= 1'b0;
                end else if (inv_en && inv_match[i]) begin
                    ent_q[i].flags[FB_V] <= 1'b0;
                end else if (fill_en && fill_idx == IW'(i)) begin
                    ent_q[i].vpn   <= fill_vpn;
                    ent_q[i].asid  <= asid_q;
                    ent_q[i].pfn   <= fill_pfn;
                    ent_q[i].flags <= fill_flags | FLAG_W'(1);
                end else if (lk_hit && lk_match[i]) begin
                    ent_q[i].flags[FB_R] <= 1'b1;
                    if (lk_acc == ACC_WRITE) ent_q[i].flags[FB_D] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] lk_match,
    input logic         lk_valid,
    input logic [1:0]   lk_acc,
    input logic         lk_hit,
    input logic [1:0]   lk_fault,
    input logic [5:0]   lk_flags,
    input logic         inv_all
);
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_fault == 2'd0 && lk_valid)); // R2
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match)); // R11
    AST_RO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_acc == 2'd1 && lk_flags[0] && !lk_flags[1])
            |-> (lk_fault == 2'd2 && !lk_hit)); // R5
    AST_NX_FAULT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_acc == 2'd2 && lk_flags[0] && !lk_flags[5])
            |-> (lk_fault == 2'd3 && !lk_hit)); // R6
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (lk_fault == 2'd0 && !lk_hit)); // R12
    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_match == '0) |-> (lk_fault == 2'd1)); // R4
endmodule

bind tlb_top tlb_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .valid_vec(valid_vec), .lk_match(lk_match),
    .lk_valid(lk_valid), .lk_acc(lk_acc), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .lk_flags(lk_flags), .inv_all(inv_all));

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        asid_we = 0;
    logic [7:0]  asid_wdata = 0;
    logic        lk_valid = 0;
    logic [19:0] lk_vpn = 0;
    logic [1:0]  lk_acc = 0;
    logic        lk_hit, lk_is_write;
    logic [19:0] lk_pfn;
    logic [1:0]  lk_fault;
    logic [5:0]  lk_flags;
    logic        fill_en = 0;
    logic [19:0] fill_vpn = 0, fill_pfn = 0;
    logic [5:0]  fill_flags = 0;
    logic        inv_en = 0;
    logic [19:0] inv_vpn = 0;
    logic        inv_all = 0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic        s_hit, s_wr;
    logic [19:0] s_pfn;
    logic [1:0]  s_flt;
    logic [5:0]  s_fl;

    always #5 clk = ~clk;

    tlb_top dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic probe(input logic [19:0] vpn, input logic [1:0] acc);
        @(negedge clk);
        lk_valid = 1; lk_vpn = vpn; lk_acc = acc;
        #1;
        s_hit = lk_hit; s_pfn = lk_pfn; s_flt = lk_fault;
        s_wr = lk_is_write; s_fl = lk_flags;
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [5:0] fl);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_flags = fl;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic set_asid(input logic [7:0] a);
        @(negedge clk); asid_we = 1; asid_wdata = a;
        @(negedge clk); asid_we = 0;
    endtask

    task automatic inv_page(input logic [19:0] vpn);
        @(negedge clk); inv_en = 1; inv_vpn = vpn;
        @(negedge clk); inv_en = 0;
    endtask

    task automatic expect_hit(input logic [19:0] vpn, input logic [19:0] pfn,
                              input string tag);
        probe(vpn, 2'd0);
        chk(s_hit && s_flt == 0 && s_pfn == pfn, tag, {s_hit, s_flt, s_pfn}, {1'b1, 2'd0, pfn});
    endtask

    task automatic expect_miss(input logic [19:0] vpn, input string tag);
        probe(vpn, 2'd0);
        chk(!s_hit && s_flt == 1, tag, {s_hit, s_flt}, 3'b001);
    endtask

    task automatic t_reset;
        expect_miss(20'h00001, "R1 lookup after reset");
        @(negedge clk); #1;
        chk(!lk_hit && lk_fault == 0, "R12 idle lookup", {lk_hit, lk_fault}, 0);
    endtask

    task automatic t_basic;
        set_asid(8'd3);
        fill(20'h12345, 20'hABCDE, 6'h26);
        expect_hit(20'h12345, 20'hABCDE, "R2 basic hit");
        probe(20'h12345, 2'd2);
        chk(s_hit && s_flt == 0, "R6 fetch of executable page", s_flt, 0);
    endtask

    task automatic t_asid;
        set_asid(8'd4);
        expect_miss(20'h12345, "R3 other tag misses");
        fill(20'h12345, 20'h11111, 6'h02);
        expect_hit(20'h12345, 20'h11111, "R13 fill tagged with register");
        set_asid(8'd3);
        expect_hit(20'h12345, 20'hABCDE, "R3 original tag hits");
    endtask

    task automatic t_miss;
        probe(20'h00777, 2'd1);
        chk(s_flt == 1 && s_wr == 1, "R4 write miss", {s_flt, s_wr}, 3'b011);
        probe(20'h00777, 2'd0);
        chk(s_flt == 1 && s_wr == 0, "R4 read miss", {s_flt, s_wr}, 3'b010);
        probe(20'h00777, 2'd2);
        chk(s_flt == 1 && s_wr == 0, "R4 fetch miss", {s_flt, s_wr}, 3'b010);
    endtask

    task automatic t_prot;
        fill(20'h00200, 20'h00022, 6'h00);
        probe(20'h00200, 2'd1);
        chk(!s_hit && s_flt == 2, "R5 read-only fault", {s_hit, s_flt}, 3'b010);
        probe(20'h00200, 2'd2);
        chk(!s_hit && s_flt == 3, "R6 no-execute fault", {s_hit, s_flt}, 3'b011);
        probe(20'h00200, 2'd0);
        chk(s_hit && s_pfn == 20'h00022 && s_fl[4:3] == 2'b00,
            "R7 faults leave ref and dirty clear", s_fl, 6'h01);
    endtask

    task automatic t_refdirty;
        fill(20'h00300, 20'h00033, 6'h02);
        probe(20'h00300, 2'd0);
        chk(s_fl[4] == 0, "R7 ref clear before first hit", s_fl, 6'h03);
        probe(20'h00300, 2'd0);
        chk(s_fl[4] == 1 && s_fl[3] == 0, "R7 ref set after read", s_fl, 6'h13);
        probe(20'h00300, 2'd1);
        probe(20'h00300, 2'd0);
        chk(s_fl[3] == 1, "R7 dirty set after write", s_fl, 6'h1B);
    endtask

    task automatic t_inv;
        inv_page(20'h12345);
        expect_miss(20'h12345, "R8 page gone for tag 3");
        set_asid(8'd4);
        expect_miss(20'h12345, "R8 page gone for tag 4");
        set_asid(8'd3);
        expect_hit(20'h00300, 20'h00033, "R8 other page kept");
    endtask

    task automatic t_invall;
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        expect_miss(20'h00300, "R9 flushed page A");
        expect_miss(20'h00200, "R9 flushed page B");
    endtask

    task automatic t_replace;
        set_asid(8'd1);
        for (int i = 0; i < 64; i++) fill(20'h01000 + 20'(i), 20'(i), 6'h02);
        expect_hit(20'h01000, 20'h0, "R10 table filled");
        fill(20'h02000, 20'h00500, 6'h02);
        expect_miss(20'h01000, "R10 first eviction at index 0");
        expect_hit(20'h02000, 20'h00500, "R10 new mapping present");
        expect_hit(20'h01001, 20'h1, "R10 neighbour kept");
        fill(20'h02001, 20'h00501, 6'h02);
        expect_miss(20'h01001, "R10 pointer advanced to index 1");
        fill(20'h01005, 20'h00099, 6'h02);
        expect_hit(20'h01005, 20'h00099, "R11 duplicate overwritten");
        expect_hit(20'h01002, 20'h2, "R11 no eviction on duplicate");
        inv_page(20'h01010);
        fill(20'h02002, 20'h00502, 6'h02);
        expect_hit(20'h02002, 20'h00502, "R10 filled into freed slot");
        expect_hit(20'h01002, 20'h2, "R10 invalid slot preferred over pointer");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset;
        t_basic;
        t_asid;
        t_miss;
        t_prot;
        t_refdirty;
        t_inv;
        t_invall;
        t_replace;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule